// File: doc/BRIEF.md
# Debug Trigger Control Register Bank

This block keeps the configuration of a small set of hardware debug triggers for a 32-bit core. Each trigger has a control word and a compare value. Software reaches them through a narrow CSR port. A select register picks the trigger that the control, compare and auxiliary registers act on. A read-only capability register reports which trigger types are available.

Every control write is legalized before it is stored. The type code must name a supported type, the debug-mode bit is always dropped, and features that are not built read as zero. Size codes that cannot be honoured become "any size". The legalized control word and compare value of every trigger are exported in parallel to a separate match unit. A one-cycle pulse per trigger tells that unit when its configuration really changed.

Top module: `trig_csr_bank`

## Requirements
- R1: A write to the select register (address 0) takes effect only when the value is below NTRIG; any larger value leaves the selection unchanged. Address 0 reads back the current index.
- R2: A control write (address 1) whose type field, bits 31:28, holds 2 or 6 stores the legalized word, including the written type. Any other type code leaves the control word unchanged. Bit 27 (debug mode) always reads 0.
- R3: The capability register (address 4) reads 0x0000_0044, bits 2 and 6 set, one for each supported type.
- R4: No stored control bit is set outside these fields: type 31:28, size, and the enable bits. The match-kind, chain, action, timing, select and hit fields therefore always read 0.
- R5: For type 2, the size code in bits 17:16 is stored as written. Every 2-bit code is legal, and bits 19:18 read 0.
- R6: For type 6, the 4-bit size code in bits 19:16 is stored when it is 0, 1, 2, 3 or 5. Any other code is stored as 0.
- R7: The enable bits are kept as written: bit 6 machine, bit 4 supervisor, bit 3 user, bit 2 execute, bit 1 store, bit 0 load. Type 6 also keeps bit 24 (virtual user) and bit 23 (virtual supervisor).
- R8: Writes to the auxiliary data register (address 3) change nothing, and the register reads 0.
- R9: After reset, the select register is 0, every control word is 0x2000_0000 and every compare value is 0.
- R10: `trig_chg_o[i]` is high for exactly the cycle after a write that altered trigger i's stored control or compare value, and is low otherwise.
- R11: Reads of addresses 1 and 2 return the selected trigger's values, and a read changes no state. The exported per-trigger values update on the clock edge that takes the write.
- R12: A compare write (address 2) stores all 32 bits in the selected trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe for this cycle |
| csr_addr | input | 3 | Register address: 0 select, 1 control, 2 compare, 3 auxiliary, 4 capability |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, combinational from csr_addr |
| trig_ctrl_o | output | NTRIG*32 | Legalized control word of each trigger, trigger i at bits 32*i+31:32*i |
| trig_cmp_o | output | NTRIG*32 | Compare value of each trigger |
| trig_chg_o | output | NTRIG | One-cycle change pulse per trigger |

## Verification
A write presented before a rising edge is stored on that edge. The exported control and compare values, the read data and the change pulse therefore all show the result one edge later. The pulse then clears on the following edge. The bench drives every write on a falling edge, lowers the strobe on the next falling edge, and samples all results right there, half a cycle after the storing edge. Read data is combinational, so each read is sampled one time unit after the address changes, with no clock edge in between.

// File: rtl/trig_csr_pkg.sv
package trig_csr_pkg;
  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    CSR_SEL  = 3'd0,
    CSR_CTRL = 3'd1,
    CSR_CMP  = 3'd2,
    CSR_AUX  = 3'd3,
    CSR_INFO = 3'd4
  } csr_addr_e;

  localparam logic [3:0]      TYPE_MATCH     = 4'd2;
  localparam logic [3:0]      TYPE_MATCH_EXT = 4'd6;
  localparam logic [XLEN-1:0] INFO_VAL       = (XLEN'(1) << TYPE_MATCH) | (XLEN'(1) << TYPE_MATCH_EXT);
  // enable bits shared by both types: M(6) S(4) U(3) X(2) ST(1) LD(0)
  localparam logic [XLEN-1:0] KEEP_BASE      = 32'h0000_005F;
  // virtual-mode enables of the extended type: VU(24) VS(23)
  localparam logic [XLEN-1:0] KEEP_VIRT      = 32'h0180_0000;
  localparam logic [XLEN-1:0] CTRL_RESET     = {TYPE_MATCH, 28'h0};
endpackage

// File: rtl/trig_ctrl_legalize.sv
module trig_ctrl_legalize
  import trig_csr_pkg::*;
(
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] legal,
  output logic            type_ok
);
  logic [3:0] w_type;
  logic [3:0] w_size;
  logic       size_ok;

  assign w_type = wdata[31:28];
  assign w_size = wdata[19:16];

  always_comb begin
    case (w_size)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd5: size_ok = 1'b1;
      default:                      size_ok = 1'b0;
    endcase
  end

  always_comb begin
    legal   = '0;
    type_ok = 1'b0;
    case (w_type)
      TYPE_MATCH: begin
        type_ok        = 1'b1;
        legal          = wdata & KEEP_BASE;
        legal[17:16]   = wdata[17:16];
        legal[31:28]   = TYPE_MATCH;
      end
      TYPE_MATCH_EXT: begin
        type_ok        = 1'b1;
        legal          = wdata & (KEEP_BASE | KEEP_VIRT);
        legal[19:16]   = size_ok ? w_size : 4'd0;
        legal[31:28]   = TYPE_MATCH_EXT;
      end
      default: begin
        type_ok = 1'b0;
        legal   = '0;
      end
    endcase
  end
endmodule

// File: rtl/trig_slot.sv
module trig_slot
  import trig_csr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_we,
  input  logic            cmp_we,
  input  logic [XLEN-1:0] ctrl_new,
  input  logic [XLEN-1:0] cmp_new,
  output logic [XLEN-1:0] ctrl_q,
  output logic [XLEN-1:0] cmp_q,
  output logic            chg_q
);
  logic [XLEN-1:0] ctrl_d;
  logic [XLEN-1:0] cmp_d;
  logic            chg_d;

  always_comb begin
    ctrl_d = ctrl_we ? ctrl_new : ctrl_q;
    cmp_d  = cmp_we  ? cmp_new  : cmp_q;
    chg_d  = (ctrl_d != ctrl_q) || (cmp_d != cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET;
      cmp_q  <= '0;
      chg_q  <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      if (cmp_we)  cmp_q  <= cmp_d;
      chg_q <= chg_d;
    end
  end
endmodule

// File: rtl/trig_rd_mux.sv
module trig_rd_mux
  import trig_csr_pkg::*;
#(
  parameter int NTRIG = 2,
  localparam int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic [2:0]            addr,
  input  logic [SEL_W-1:0]      sel,
  input  logic [NTRIG*XLEN-1:0] ctrl_flat,
  input  logic [NTRIG*XLEN-1:0] cmp_flat,
  output logic [XLEN-1:0]       rdata
);
  logic [XLEN-1:0] ctrl_arr [NTRIG];
  logic [XLEN-1:0] cmp_arr  [NTRIG];

  for (genvar i = 0; i < NTRIG; i++) begin : g_unpack
    assign ctrl_arr[i] = ctrl_flat[i*XLEN +: XLEN];
    assign cmp_arr[i]  = cmp_flat[i*XLEN +: XLEN];
  end

  always_comb begin
    case (addr)
      CSR_SEL:  rdata = XLEN'(sel);
      CSR_CTRL: rdata = ctrl_arr[sel];
      CSR_CMP:  rdata = cmp_arr[sel];
      CSR_INFO: rdata = INFO_VAL;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/trig_csr_bank.sv
module trig_csr_bank
  import trig_csr_pkg::*;
#(
  parameter int NTRIG = 2,
  localparam int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csr_we,
  input  logic [2:0]            csr_addr,
  input  logic [XLEN-1:0]       csr_wdata,
  output logic [XLEN-1:0]       csr_rdata,
  output logic [NTRIG*XLEN-1:0] trig_ctrl_o,
  output logic [NTRIG*XLEN-1:0] trig_cmp_o,
  output logic [NTRIG-1:0]      trig_chg_o
);
  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic             sel_en;
  logic [XLEN-1:0]  ctrl_legal;
  logic             type_ok;
  logic             wr_ctrl;
  logic             wr_cmp;

  assign wr_ctrl = csr_we && (csr_addr == CSR_CTRL) && type_ok;
  assign wr_cmp  = csr_we && (csr_addr == CSR_CMP);

  always_comb begin
    sel_en = csr_we && (csr_addr == CSR_SEL) && (csr_wdata < XLEN'(NTRIG));
    sel_d  = sel_en ? csr_wdata[SEL_W-1:0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  trig_ctrl_legalize u_legal (
    .wdata   (csr_wdata),
    .legal   (ctrl_legal),
    .type_ok (type_ok)
  );

  for (genvar i = 0; i < NTRIG; i++) begin : g_slot
    logic hit;
    assign hit = (sel_q == SEL_W'(i));
    trig_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (wr_ctrl && hit),
      .cmp_we   (wr_cmp && hit),
      .ctrl_new (ctrl_legal),
      .cmp_new  (csr_wdata),
      .ctrl_q   (trig_ctrl_o[i*XLEN +: XLEN]),
      .cmp_q    (trig_cmp_o[i*XLEN +: XLEN]),
      .chg_q    (trig_chg_o[i])
    );
  end

  trig_rd_mux #(.NTRIG(NTRIG)) u_rd (
    .addr      (csr_addr),
    .sel       (sel_q),
    .ctrl_flat (trig_ctrl_o),
    .cmp_flat  (trig_cmp_o),
    .rdata     (csr_rdata)
  );
endmodule

// File: rtl/trig_csr_bank_chk.sv
module trig_csr_bank_chk
  import trig_csr_pkg::*;
#(
  parameter int NTRIG = 2,
  localparam int SEL_W = (NTRIG > 1) ? $clog2(NTRIG) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  csr_we,
  input logic [2:0]            csr_addr,
  input logic [XLEN-1:0]       csr_wdata,
  input logic [XLEN-1:0]       csr_rdata,
  input logic [NTRIG*XLEN-1:0] trig_ctrl_o,
  input logic [NTRIG*XLEN-1:0] trig_cmp_o,
  input logic [NTRIG-1:0]      trig_chg_o,
  input logic [SEL_W-1:0]      sel_q
);
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_q) < NTRIG); // R1
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == CSR_SEL && csr_wdata >= XLEN'(NTRIG)) |=> $stable(sel_q)); // R1
  AST_INFO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_addr == CSR_INFO) |-> (csr_rdata == 32'h0000_0044)); // R3
  AST_AUX_NOEFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == CSR_AUX) |=> ($stable(trig_ctrl_o) && $stable(trig_cmp_o))); // R8

  for (genvar i = 0; i < NTRIG; i++) begin : g_chk
    logic [XLEN-1:0] c;
    assign c = trig_ctrl_o[i*XLEN +: XLEN];
    AST_DMODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      c[27] == 1'b0); // R2
    AST_TYPE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (c[31:28] == TYPE_MATCH) || (c[31:28] == TYPE_MATCH_EXT)); // R2
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (c & ~(32'hF00F_005F | ((c[31:28] == TYPE_MATCH_EXT) ? 32'h0180_0000 : 32'h0))) == 32'h0
      && ((c[31:28] == TYPE_MATCH_EXT) || c[19:18] == 2'b00)); // R4
    AST_EXT_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      (c[31:28] == TYPE_MATCH_EXT) |-> (c[19:16] <= 4'd3 || c[19:16] == 4'd5)); // R6
    AST_CHG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      trig_chg_o[i] |-> $past(csr_we && (csr_addr == CSR_CTRL || csr_addr == CSR_CMP)
                              && sel_q == SEL_W'(i))); // R10
  end
endmodule

bind trig_csr_bank trig_csr_bank_chk #(.NTRIG(NTRIG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_we      (csr_we),
  .csr_addr    (csr_addr),
  .csr_wdata   (csr_wdata),
  .csr_rdata   (csr_rdata),
  .trig_ctrl_o (trig_ctrl_o),
  .trig_cmp_o  (trig_cmp_o),
  .trig_chg_o  (trig_chg_o),
  .sel_q       (sel_q)
);

// File: tb/trig_csr_bank_bench.sv
`timescale 1ns/1ps
module trig_csr_bank_bench;
  localparam int NT = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           csr_we;
  logic [2:0]     csr_addr;
  logic [31:0]    csr_wdata;
  logic [31:0]    csr_rdata;
  logic [NT*32-1:0] trig_ctrl_o;
  logic [NT*32-1:0] trig_cmp_o;
  logic [NT-1:0]  trig_chg_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [31:0] ec [NT];
  logic [31:0] ep [NT];
  int          esel;

  always #2.5 clk = ~clk;

  trig_csr_bank #(.NTRIG(NT)) u_trig_csr_bank (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .trig_ctrl_o(trig_ctrl_o),
    .trig_cmp_o(trig_cmp_o), .trig_chg_o(trig_chg_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [2:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  function automatic logic [31:0] legal_of(input logic [31:0] old, input logic [31:0] w);
    logic [31:0] r = 32'h0;
    logic [3:0]  s = w[19:16];
    if (w[31:28] == 4'd2) begin
      r[31:28] = 4'd2; r[17] = w[17]; r[16] = w[16];
      r[6] = w[6]; r[4:0] = w[4:0];
    end else if (w[31:28] == 4'd6) begin
      r[31:28] = 4'd6; r[24] = w[24]; r[23] = w[23];
      r[6] = w[6]; r[4:0] = w[4:0];
      r[19:16] = (s <= 4'd3 || s == 4'd5) ? s : 4'd0;
    end else begin
      r = old;
    end
    return r;
  endfunction

  task automatic check_outputs(input string req, input logic [NT-1:0] echg);
    for (int i = 0; i < NT; i++) begin
      chk(trig_ctrl_o[i*32 +: 32] == ec[i], req, trig_ctrl_o[i*32 +: 32], ec[i]);
      chk(trig_cmp_o[i*32 +: 32] == ep[i], req, trig_cmp_o[i*32 +: 32], ep[i]);
    end
    chk(trig_chg_o == echg, {req, " R10"}, 32'(trig_chg_o), 32'(echg));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] d;
    logic [31:0] nc;
    logic [NT-1:0] echg;
    int k = 1;
    rst_n = 1'b0; csr_we = 1'b0; csr_addr = 3'd0; csr_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NT; i++) begin ec[i] = 32'h2000_0000; ep[i] = 32'h0; end
    esel = 0;

    // R9: reset values
    @(negedge clk);
    check_outputs("R9 reset", '0);
    csr_rd(3'd0, rd); chk(rd == 32'd0, "R9 select reset", rd, 32'd0);
    csr_rd(3'd1, rd); chk(rd == 32'h2000_0000, "R9 ctrl reset", rd, 32'h2000_0000);
    csr_rd(3'd4, rd); chk(rd == 32'h44, "R3 info", rd, 32'h44);

    // R1: select sweep including out-of-range values
    for (int v = 0; v < 9; v++) begin
      d = (v == 8) ? 32'h8000_0001 : 32'(v);
      csr_wr(3'd0, d);
      if (d < NT) esel = int'(d);
      csr_rd(3'd0, rd);
      chk(rd == 32'(esel), "R1 select", rd, 32'(esel));
    end

    // R2 R4 R5 R6 R7: control legalization sweep over every type and size code
    for (int t = 0; t < NT; t++) begin
      csr_wr(3'd0, 32'(t)); esel = t;
      for (int ty = 0; ty < 16; ty++) begin
        for (int sz = 0; sz < 16; sz++) begin
          d = 32'h9E37_79B9 * 32'(k) ^ (32'(k) << 7);
          k++;
          d[31:28] = 4'(ty); d[19:16] = 4'(sz);
          if (k[0]) d[27] = 1'b1;
          nc = legal_of(ec[t], d);
          echg = '0;
          echg[t] = (nc != ec[t]);
          csr_wr(3'd1, d);
          ec[t] = nc;
          check_outputs("R2 R4 R5 R6 R7 ctrl", echg);
          csr_rd(3'd1, rd);
          chk(rd == ec[t], "R11 ctrl read", rd, ec[t]);
        end
      end
      // R10: identical rewrite yields no pulse
      d = 32'h6180_005F | 32'h0005_0000;
      csr_wr(3'd1, d); ec[t] = legal_of(ec[t], d);
      csr_wr(3'd1, d);
      check_outputs("R10 repeat ctrl", '0);
    end

    // R12 R11: compare values, repeat, auxiliary writes
    for (int t = 0; t < NT; t++) begin
      csr_wr(3'd0, 32'(t)); esel = t;
      for (int j = 0; j < 20; j++) begin
        d = 32'hA5A5_0000 ^ (32'h0101_0101 * 32'(j + t * 20)) ^ (32'(j) << 27);
        echg = '0; echg[t] = (d != ep[t]);
        csr_wr(3'd2, d); ep[t] = d;
        check_outputs("R12 cmp", echg);
        csr_rd(3'd2, rd); chk(rd == d, "R11 cmp read", rd, d);
      end
      csr_wr(3'd2, ep[t]);
      check_outputs("R10 repeat cmp", '0);
      csr_wr(3'd3, 32'hFFFF_FFFF);
      check_outputs("R8 aux write", '0);
      csr_rd(3'd3, rd); chk(rd == 32'h0, "R8 aux read", rd, 32'h0);
    end

    // R11: reads follow the selection and have no side effects
    for (int t = 0; t < NT; t++) begin
      csr_wr(3'd0, 32'(t));
      csr_rd(3'd1, rd); chk(rd == ec[t], "R11 sel ctrl", rd, ec[t]);
      csr_rd(3'd2, rd); chk(rd == ep[t], "R11 sel cmp", rd, ep[t]);
      @(negedge clk);
      check_outputs("R11 read no effect", '0);
    end
    csr_rd(3'd4, rd); chk(rd == 32'h44, "R3 info late", rd, 32'h44);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule